// File: doc/BRIEF.md
# Sub-word Compare and Dual Predicate Writer

This unit compares two narrow integer operands taken from 32-bit words and records the outcome in a small predicate register file. Each operand is one byte lane or one halfword of its source word. The second operand may instead come from a 16-bit immediate, which is zero-extended or sign-extended. The single-bit compare result is merged with a source predicate through a selectable boolean operator.

One issue writes two destinations on the same clock edge. The primary destination receives the merged compare. The secondary destination receives the merged inverse of the compare. The secondary write is dropped when its index names the constant entry. Naming the constant entry as the primary destination is an encoding fault. The unit flags it for one cycle.

The file has eight entries. The top entry always reads as true. The whole file is visible on an output bus so that a consumer can read any predicate.

Top module: `subword_cmp_pred`

## Requirements
- R1: While `rst` is high at a rising edge, entries 0 to 6 clear to 0 and `dst_err` clears to 0. After that edge `pred_bits` reads 8'h80.
- R2: Lane code selects the operand as a zero-extended value. Codes 0 to 3 select byte lane 0 to 3, meaning bits [8k+7:8k]. Code 4 selects bits [15:0]. Code 5 selects bits [31:16]. Codes 6 and 7 behave like code 4.
- R3: When `b_from_reg` is 1, B comes from `b_word` through `b_lane` and `b_imm` is ignored. When it is 0, B is `b_imm`. The immediate is sign-extended to 32 bits if `b_signed` is 1 and zero-extended otherwise.
- R4: The compare is a signed 32-bit compare when `a_signed` or `b_signed` is 1. Otherwise it is unsigned.
- R5: `cond` encoding: 0 is always false, 1 is A<B, 2 is A==B, 3 is A<=B, 4 is A>B, 5 is A!=B, 6 is A>=B, and 7 is always true.
- R6: `comb` encoding: 0 is AND, 1 is OR, 2 is XOR, and 3 acts as AND.
- R7: On a rising edge with `issue` high, entry `dst_p_idx` takes (compare `comb` source predicate). The source predicate is the entry at `src_idx`, read before the edge. The new value is visible on `pred_bits` after that edge.
- R8: On the same edge, entry `dst_q_idx` takes ((NOT compare) `comb` source predicate).
- R9: When `dst_q_idx` is 7, no secondary write happens.
- R10: When `dst_p_idx` is 7 on an issue, no primary write happens and the secondary write still proceeds. `dst_err` is 1 for the cycle after that edge and 0 after any edge without such an issue.
- R11: Entry 7 always reads 1, ignores writes, and gives a true source predicate.
- R12: When `dst_p_idx` equals `dst_q_idx` and both are below 7, the secondary value is the one stored.
- R13: An edge with `issue` low leaves `pred_bits` unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Perform compare and writes on this edge |
| a_word | input | 32 | Source word for operand A |
| a_lane | input | 3 | Lane code for A |
| a_signed | input | 1 | A marked signed |
| b_word | input | 32 | Source word for operand B |
| b_lane | input | 3 | Lane code for B |
| b_signed | input | 1 | B marked signed; also picks immediate extension |
| b_from_reg | input | 1 | 1: B from word, 0: B from immediate |
| b_imm | input | 16 | Immediate for B |
| cond | input | 3 | Compare condition code |
| comb | input | 2 | Boolean combiner code |
| src_idx | input | 3 | Source predicate index |
| dst_p_idx | input | 3 | Primary destination index |
| dst_q_idx | input | 3 | Secondary destination index (7 = none) |
| pred_bits | output | 8 | Current predicate file contents |
| dst_err | output | 1 | Primary destination named the constant entry |

## Verification
The assertions on combiner outcomes assume that the two destinations differ and that neither is the constant entry. The bench's directed steps use such distinct destination pairs, except in the dedicated cases that deliberately alias them or name entry 7. Those cases are covered only by the properties for the error flag and for the unchanged file. Every stimulus field is driven to a defined value before `issue` rises, so no property sees unknown indices.

// File: rtl/swcmp_pkg.sv
package swcmp_pkg;

    localparam int WORD_W = 32;
    localparam int IMM_W  = 16;
    localparam int LANE_W = 8;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        LANE_B0, LANE_B1, LANE_B2, LANE_B3,
        LANE_HLO, LANE_HHI, LANE_ALT6, LANE_ALT7
    } lane_sel_e;

    typedef enum logic [2:0] {
        CMP_NEVER, CMP_LT, CMP_EQ, CMP_LE,
        CMP_GT, CMP_NE, CMP_GE, CMP_ALWAYS
    } cmp_cond_e;

    typedef enum logic [1:0] {
        CMB_AND, CMB_OR, CMB_XOR, CMB_RSVD
    } comb_e;

    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic              sgn;
    } opnd_t;

    function automatic logic [WORD_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                     input lane_sel_e s);
        logic [WORD_W-1:0] r;
        case (s)
            LANE_B0, LANE_B1, LANE_B2, LANE_B3:
                r = (w >> (LANE_W * int'(s[1:0]))) & WORD_W'({LANE_W{1'b1}});
            LANE_HHI:
                r = w >> HALF_W;
            default:
                r = w & WORD_W'({HALF_W{1'b1}});
        endcase
        return r;
    endfunction

    function automatic logic merge(input logic x, input logic y, input comb_e c);
        logic r;
        case (c)
            CMB_OR:  r = x | y;
            CMB_XOR: r = x ^ y;
            default: r = x & y;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/swcmp_lane.sv
module swcmp_lane
    import swcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        lane,
    input  logic              sgn,
    output opnd_t             opnd
);
    always_comb begin
        opnd.val = pick_lane(word, lane_sel_e'(lane));
        opnd.sgn = sgn;
    end
endmodule

// File: rtl/swcmp_compare.sv
module swcmp_compare
    import swcmp_pkg::*;
(
    input  opnd_t       op_a,
    input  opnd_t       op_b,
    input  logic [2:0]  cond,
    output logic        hit
);
    logic signed_mode, lt, eq;

    always_comb begin
        signed_mode = op_a.sgn | op_b.sgn;
        lt = signed_mode ? ($signed(op_a.val) < $signed(op_b.val)) : (op_a.val < op_b.val);
        eq = (op_a.val == op_b.val);
        case (cmp_cond_e'(cond))
            CMP_LT:     hit = lt;
            CMP_EQ:     hit = eq;
            CMP_LE:     hit = lt | eq;
            CMP_GT:     hit = ~(lt | eq);
            CMP_NE:     hit = ~eq;
            CMP_GE:     hit = ~lt;
            CMP_ALWAYS: hit = 1'b1;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/swcmp_predfile.sv
module swcmp_predfile #(
    parameter int PRED_N = 8,
    localparam int PIDX_W = $clog2(PRED_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_en,
    input  logic [PIDX_W-1:0] wp_idx,
    input  logic              wp_d,
    input  logic              wq_en,
    input  logic [PIDX_W-1:0] wq_idx,
    input  logic              wq_d,
    input  logic [PIDX_W-1:0] rd_idx,
    output logic              rd_d,
    output logic [PRED_N-1:0] bits
);
    localparam int CONST_I = PRED_N - 1;

    for (genvar i = 0; i < PRED_N; i++) begin : g_ent
        if (i == CONST_I) begin : g_const
            assign bits[i] = 1'b1;
        end else begin : g_reg
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (wq_en && wq_idx == PIDX_W'(i))
                    q <= wq_d;
                else if (wp_en && wp_idx == PIDX_W'(i))
                    q <= wp_d;
            end
            assign bits[i] = q;
        end
    end

    assign rd_d = bits[rd_idx];
endmodule

// File: rtl/subword_cmp_pred.sv
module subword_cmp_pred
    import swcmp_pkg::*;
#(
    parameter int PRED_N = 8,
    localparam int PIDX_W = $clog2(PRED_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [31:0]       a_word,
    input  logic [2:0]        a_lane,
    input  logic              a_signed,
    input  logic [31:0]       b_word,
    input  logic [2:0]        b_lane,
    input  logic              b_signed,
    input  logic              b_from_reg,
    input  logic [15:0]       b_imm,
    input  logic [2:0]        cond,
    input  logic [1:0]        comb,
    input  logic [PIDX_W-1:0] src_idx,
    input  logic [PIDX_W-1:0] dst_p_idx,
    input  logic [PIDX_W-1:0] dst_q_idx,
    output logic [PRED_N-1:0] pred_bits,
    output logic              dst_err
);
    localparam logic [PIDX_W-1:0] CONST_IDX = PIDX_W'(PRED_N - 1);

    opnd_t op_a, op_b_reg, op_b;
    logic  hit, src_val, p_val, q_val, wp_en, wq_en, bad_p;

    swcmp_lane u_lane_a (.word(a_word), .lane(a_lane), .sgn(a_signed), .opnd(op_a));
    swcmp_lane u_lane_b (.word(b_word), .lane(b_lane), .sgn(b_signed), .opnd(op_b_reg));

    always_comb begin
        if (b_from_reg) begin
            op_b = op_b_reg;
        end else begin
            op_b.sgn = b_signed;
            op_b.val = b_signed ? WORD_W'($signed(b_imm)) : WORD_W'(b_imm);
        end
    end

    swcmp_compare u_cmp (.op_a(op_a), .op_b(op_b), .cond(cond), .hit(hit));

    always_comb begin
        p_val = merge(hit,  src_val, comb_e'(comb));
        q_val = merge(~hit, src_val, comb_e'(comb));
        bad_p = issue && (dst_p_idx == CONST_IDX);
        wp_en = issue && (dst_p_idx != CONST_IDX);
        wq_en = issue && (dst_q_idx != CONST_IDX);
    end

    swcmp_predfile #(.PRED_N(PRED_N)) u_pf (
        .clk(clk), .rst(rst),
        .wp_en(wp_en), .wp_idx(dst_p_idx), .wp_d(p_val),
        .wq_en(wq_en), .wq_idx(dst_q_idx), .wq_d(q_val),
        .rd_idx(src_idx), .rd_d(src_val),
        .bits(pred_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) dst_err <= 1'b0;
        else     dst_err <= bad_p;
    end
endmodule

// File: rtl/swcmp_chk.sv
module swcmp_chk #(
    parameter int PRED_N = 8,
    localparam int PIDX_W = $clog2(PRED_N)
) (
    input logic              clk,
    input logic              rst,
    input logic              issue,
    input logic [1:0]        comb,
    input logic [PIDX_W-1:0] dst_p_idx,
    input logic [PIDX_W-1:0] dst_q_idx,
    input logic [PRED_N-1:0] pred_bits,
    input logic              dst_err
);
    localparam logic [PIDX_W-1:0] C = PIDX_W'(PRED_N - 1);
    localparam logic [PRED_N-1:0] RST_V = PRED_N'(1) << (PRED_N - 1);

    logic pair_ok;
    assign pair_ok = issue && dst_p_idx != C && dst_q_idx != C && dst_p_idx != dst_q_idx;

    // R1
    reset_value_chk: assert property (@(posedge clk) rst |=> pred_bits == RST_V);

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(pred_bits));

    // R9
    both_const_hold_chk: assert property (@(posedge clk) disable iff (rst)
        issue && dst_p_idx == C && dst_q_idx == C |=> $stable(pred_bits));

    // R10
    err_raise_chk: assert property (@(posedge clk) disable iff (rst)
        issue && dst_p_idx == C |=> dst_err);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(issue && dst_p_idx == C) |=> !dst_err);

    // R6 R8
    xor_split_chk: assert property (@(posedge clk) disable iff (rst)
        pair_ok && comb == 2'd2 |=>
        pred_bits[$past(dst_p_idx)] != pred_bits[$past(dst_q_idx)]);

    // R6 R8
    and_split_chk: assert property (@(posedge clk) disable iff (rst)
        pair_ok && (comb == 2'd0 || comb == 2'd3) |=>
        !(pred_bits[$past(dst_p_idx)] && pred_bits[$past(dst_q_idx)]));

    // R6 R8
    or_split_chk: assert property (@(posedge clk) disable iff (rst)
        pair_ok && comb == 2'd1 |=>
        (pred_bits[$past(dst_p_idx)] || pred_bits[$past(dst_q_idx)]));
endmodule

bind subword_cmp_pred swcmp_chk #(.PRED_N(PRED_N)) u_chk (
    .clk(clk), .rst(rst), .issue(issue), .comb(comb),
    .dst_p_idx(dst_p_idx), .dst_q_idx(dst_q_idx),
    .pred_bits(pred_bits), .dst_err(dst_err)
);

// File: tb/tb_subword_cmp_pred.sv
`timescale 1ns/1ps
module tb_subword_cmp_pred;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [31:0] a_word = '0, b_word = '0;
    logic [2:0]  a_lane = '0, b_lane = '0, cond = '0;
    logic        a_signed = 1'b0, b_signed = 1'b0, b_from_reg = 1'b0;
    logic [15:0] b_imm = '0;
    logic [1:0]  comb = '0;
    logic [2:0]  src_idx = 3'd7, dst_p_idx = 3'd0, dst_q_idx = 3'd1;
    logic [7:0]  pred_bits;
    logic        dst_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] exp_pf = 8'h80;
    logic       exp_err = 1'b0;

    always #2 clk = ~clk;

    subword_cmp_pred dut (
        .clk(clk), .rst(rst), .issue(issue),
        .a_word(a_word), .a_lane(a_lane), .a_signed(a_signed),
        .b_word(b_word), .b_lane(b_lane), .b_signed(b_signed),
        .b_from_reg(b_from_reg), .b_imm(b_imm),
        .cond(cond), .comb(comb), .src_idx(src_idx),
        .dst_p_idx(dst_p_idx), .dst_q_idx(dst_q_idx),
        .pred_bits(pred_bits), .dst_err(dst_err)
    );

    typedef struct packed {
        logic [31:0] a;  logic [2:0] al; logic as_;
        logic [31:0] b;  logic [2:0] bl; logic bs; logic breg;
        logic [15:0] imm; logic [2:0] cnd; logic exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1234, 3'd0, 1'b0, 32'h0000_0034, 3'd0, 1'b0, 1'b1, 16'h0099, 3'd2, 1'b1},
        '{32'h1234_5678, 3'd2, 1'b0, 32'hAB00_0000, 3'd3, 1'b0, 1'b1, 16'hFFFF, 3'd1, 1'b1},
        '{32'h80FF_0000, 3'd5, 1'b1, 32'h0000_7FFF, 3'd4, 1'b0, 1'b1, 16'h0000, 3'd4, 1'b1},
        '{32'h0000_FF00, 3'd1, 1'b0, 32'h0,         3'd0, 1'b1, 1'b0, 16'hFFFF, 3'd4, 1'b1},
        '{32'h0000_FF00, 3'd1, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'hFFFF, 3'd4, 1'b0},
        '{32'h0000_0010, 3'd0, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h0010, 3'd3, 1'b1},
        '{32'h0000_0010, 3'd0, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h0010, 3'd5, 1'b0},
        '{32'h0000_0005, 3'd4, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h0006, 3'd6, 1'b0},
        '{32'h0000_0005, 3'd4, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h0006, 3'd0, 1'b0},
        '{32'h0000_0005, 3'd4, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h0006, 3'd7, 1'b1},
        '{32'hABCD_1234, 3'd6, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h1234, 3'd2, 1'b1},
        '{32'h0000_0001, 3'd0, 1'b0, 32'h0,         3'd0, 1'b1, 1'b0, 16'h8000, 3'd1, 1'b0},
        '{32'h0000_0001, 3'd0, 1'b0, 32'h0,         3'd0, 1'b0, 1'b0, 16'h8000, 3'd1, 1'b1},
        '{32'hABCD_1234, 3'd7, 1'b0, 32'h5678_1234, 3'd4, 1'b0, 1'b1, 16'h0000, 3'd2, 1'b1}
    };

    function automatic logic mrg(input logic x, input logic y, input logic [1:0] c);
        if (c == 2'd1) return x | y;
        if (c == 2'd2) return x ^ y;
        return x & y;
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Model the effect of one issue, then drive it for one edge and compare.
    task automatic do_op(input logic c, input logic [1:0] cb, input logic [2:0] s,
                         input logic [2:0] dp, input logic [2:0] dq, input string tag);
        logic sv;
        sv = exp_pf[s];
        @(negedge clk);
        comb = cb; src_idx = s; dst_p_idx = dp; dst_q_idx = dq; issue = 1'b1;
        if (dp != 3'd7) exp_pf[dp] = mrg(c, sv, cb);
        if (dq != 3'd7) exp_pf[dq] = mrg(~c, sv, cb);
        exp_pf[7] = 1'b1;
        exp_err = (dp == 3'd7);
        @(negedge clk);
        issue = 1'b0;
        check(tag, {dst_err, pred_bits}, {exp_err, exp_pf});
        exp_err = 1'b0;
    endtask

    task automatic set_const_cmp(input logic [2:0] cnd);
        a_word = '0; a_lane = '0; a_signed = 0; b_word = '0; b_lane = '0;
        b_signed = 0; b_from_reg = 1; b_imm = '0; cond = cnd;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog all-R actual=%0d expected=<20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {dst_err, pred_bits}, {1'b0, 8'h80});

        // Table walk: R2 R3 R4 R5 R7 R8 with AND and true source (R11)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_word = VECS[i].a; a_lane = VECS[i].al; a_signed = VECS[i].as_;
            b_word = VECS[i].b; b_lane = VECS[i].bl; b_signed = VECS[i].bs;
            b_from_reg = VECS[i].breg; b_imm = VECS[i].imm; cond = VECS[i].cnd;
            do_op(VECS[i].exp, 2'd0, 3'd7, 3'd0, 3'd1, $sformatf("R2_R3_R4_R5_R7_R8 vec %0d", i));
        end

        // R9: secondary skipped, p2 set
        set_const_cmp(3'd7);
        do_op(1'b1, 2'd0, 3'd7, 3'd2, 3'd7, "R9 secondary skip");
        // R6 OR with source p2=1
        set_const_cmp(3'd0);
        do_op(1'b0, 2'd1, 3'd2, 3'd3, 3'd4, "R6 OR");
        // R6 XOR
        set_const_cmp(3'd7);
        do_op(1'b1, 2'd2, 3'd2, 3'd3, 3'd4, "R6 XOR");
        // R6 code 3 acts as AND
        do_op(1'b1, 2'd3, 3'd2, 3'd5, 3'd6, "R6 code3 AND");
        // R6 AND with false source p0 (currently 1 from last vector? use p1=0)
        do_op(1'b1, 2'd0, 3'd1, 3'd5, 3'd6, "R6 AND false source");

        // R10: constant primary, secondary still written
        set_const_cmp(3'd0);
        do_op(1'b0, 2'd1, 3'd7, 3'd7, 3'd0, "R10 const primary");
        @(negedge clk);
        check("R10 err clears", {8'h00, dst_err}, 9'h0);
        check("R11 entry7 stays 1", {8'h00, pred_bits[7]}, 9'h1);

        // R12: same destination, secondary wins
        set_const_cmp(3'd7);
        do_op(1'b1, 2'd0, 3'd7, 3'd1, 3'd1, "R12 alias pre");
        check("R12 alias value", {8'h00, pred_bits[1]}, 9'h0);

        // R13: no issue, wild inputs
        @(negedge clk);
        a_word = 32'hFFFF_FFFF; cond = 3'd7; comb = 2'd1; src_idx = 3'd7;
        dst_p_idx = 3'd1; dst_q_idx = 3'd3; b_imm = 16'h5A5A;
        repeat (3) @(negedge clk);
        check("R13 idle hold", {dst_err, pred_bits}, {1'b0, exp_pf});

        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_pf = 8'h80;
        check("R1 mid-run reset", {dst_err, pred_bits}, {1'b0, 8'h80});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule